// File: doc/BRIEF.md
# GPIO External Interrupt Bank

This block watches a group of general-purpose input lines (up to 32) and turns selected activity on them into interrupt requests. Every line carries a 4-bit trigger-mode field, an enable bit and a sticky pending bit. The supported triggers are rising edge, falling edge, both edges, high level and low level. Each pending bit that is set on an enabled line contributes to one combined, registered interrupt output.

Software reaches the bank through a plain 32-bit register port. A write strobe, a word address and write data go in. Read data comes back combinationally for the address presented. Eight mode fields are packed into each configuration word. The enable word gates both the recording of events and the interrupt output. The pending word is cleared by writing ones, so an interrupt handler can read the word and write the same value back to acknowledge every event it has seen. The inputs are asynchronous to the bank clock and are resynchronised inside the block.

Top module: `gpio_eint_bank`

## Requirements
- R1: After reset every configuration word, the enable word and the pending word read 0, and `irq_o` is 0.
- R2: The mode of line n occupies bits [4*(n%8)+3 : 4*(n%8)] of configuration word n/8. Configuration word k sits at byte offset 4*k (0x00, 0x04, 0x08, 0x0C). A write replaces the whole word, and a read returns it unchanged.
- R3: The trigger codes are 0 for a rising edge, 1 for a falling edge, 2 for a high level, 3 for a low level and 4 for either edge. Codes 5 to 15 never set a pending bit.
- R4: The enable word is at offset 0x10, and bit n belongs to line n. Writing it leaves every mode field unchanged.
- R5: The pending word is at offset 0x14. Writing a 1 to bit n clears pending bit n, and bits written as 0 keep their value. A pending word with nothing set reads 0.
- R6: In the level modes the pending bit is set again on every clock while the level holds. When a hardware set and a software clear hit the same bit in one cycle, the bit stays set.
- R7: A pending bit is set only while its enable bit is 1. Clearing the enable bit does not clear a pending bit that is already set.
- R8: A change on an input that is applied between two clock edges shows in the pending word after the third rising edge that follows. `irq_o` follows one edge later and equals the OR over all lines of pending AND enable, taken from the previous cycle.

Ports are listed in port-list order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bank clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pins_i | input | NUM_LINES | Asynchronous input lines being watched |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Byte address within the bank |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Corrupted mode storage or a wrong field position appears at the ports as a pending bit on the wrong line, or as no pending bit at all. It also appears as a configuration word that does not read back as written. Either is visible within four clocks of the input change or at the first readback. A broken edge-history or synchroniser register shifts the pending bit by a cycle, which the exact-latency check catches, or produces events where no edge occurred. Pending-bit errors, such as a lost set, a clear of the wrong bit or a clear that wins over a set, show on the next read of offset 0x14. They also show at `irq_o` one clock later.

// File: rtl/gpio_eint_pkg.sv
package gpio_eint_pkg;

  typedef enum logic [3:0] {
    TRIG_RISE = 4'd0,
    TRIG_FALL = 4'd1,
    TRIG_HIGH = 4'd2,
    TRIG_LOW  = 4'd3,
    TRIG_BOTH = 4'd4
  } trig_mode_e;

  localparam int unsigned MODE_W     = 4;
  localparam int unsigned LINES_PER_WORD = 8;
  localparam int unsigned WORD_EN    = 4;
  localparam int unsigned WORD_STAT  = 5;

endpackage

// File: rtl/gpio_eint_sync.sv
module gpio_eint_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);

  logic [W-1:0] meta_q;
  logic [W-1:0] stable_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q   <= '0;
      stable_q <= '0;
    end else begin
      meta_q   <= async_i;
      stable_q <= meta_q;
    end
  end

  assign sync_o = stable_q;

endmodule

// File: rtl/gpio_eint_trigger.sv
module gpio_eint_trigger
  import gpio_eint_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [W-1:0]        level_i,
  input  logic [MODE_W*W-1:0] mode_i,
  output logic [W-1:0]        hit_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= level_i;
    end
  end

  for (genvar g = 0; g < W; g++) begin : g_line
    logic       now_v;
    logic       was_v;
    trig_mode_e sel_v;

    assign now_v = level_i[g];
    assign was_v = prev_q[g];
    assign sel_v = trig_mode_e'(mode_i[MODE_W*g +: MODE_W]);

    always_comb begin
      case (sel_v)
        TRIG_RISE: hit_o[g] = now_v & ~was_v;
        TRIG_FALL: hit_o[g] = ~now_v & was_v;
        TRIG_HIGH: hit_o[g] = now_v;
        TRIG_LOW:  hit_o[g] = ~now_v;
        TRIG_BOTH: hit_o[g] = now_v ^ was_v;
        default:   hit_o[g] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_eint_regs.sv
module gpio_eint_regs
  import gpio_eint_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic [31:0]         wdata_i,
  input  logic [W-1:0]        hit_i,
  output logic [31:0]         rdata_o,
  output logic [MODE_W*W-1:0] mode_o,
  output logic [W-1:0]        en_o,
  output logic [W-1:0]        pend_o,
  output logic [W-1:0]        clr_o
);

  localparam int unsigned WORD_W    = ADDR_W - 2;
  localparam int unsigned CFG_WORDS = (W + LINES_PER_WORD - 1) / LINES_PER_WORD;

  logic [WORD_W-1:0]   word_idx;
  logic [MODE_W*W-1:0] mode_q, mode_n;
  logic [W-1:0]        en_q, en_n;
  logic [W-1:0]        pend_q, pend_n;
  logic [CFG_WORDS-1:0] cfg_sel;
  logic                mode_ld;
  logic                en_ld;
  logic                stat_wr;

  assign word_idx = addr_i[ADDR_W-1:2];

  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_cfg_sel
    assign cfg_sel[k] = we_i && (word_idx == WORD_W'(k));
  end

  assign mode_ld = |cfg_sel;
  assign en_ld   = we_i && (word_idx == WORD_W'(WORD_EN));
  assign stat_wr = we_i && (word_idx == WORD_W'(WORD_STAT));

  // next-state logic
  always_comb begin
    mode_n = mode_q;
    for (int l = 0; l < int'(W); l++) begin
      if (cfg_sel[l / LINES_PER_WORD]) begin
        mode_n[MODE_W*l +: MODE_W] = wdata_i[MODE_W*(l % LINES_PER_WORD) +: MODE_W];
      end
    end
  end

  assign en_n   = wdata_i[W-1:0];
  assign clr_o  = stat_wr ? wdata_i[W-1:0] : '0;
  // hardware set is ORed after the clear, so it wins on a collision
  assign pend_n = (pend_q & ~clr_o) | (hit_i & en_q);

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      en_q   <= '0;
      pend_q <= '0;
    end else begin
      if (mode_ld) begin
        mode_q <= mode_n;
      end
      if (en_ld) begin
        en_q <= en_n;
      end
      pend_q <= pend_n;
    end
  end

  // read mux
  always_comb begin
    rdata_o = '0;
    if (word_idx == WORD_W'(WORD_EN)) begin
      rdata_o[W-1:0] = en_q;
    end else if (word_idx == WORD_W'(WORD_STAT)) begin
      rdata_o[W-1:0] = pend_q;
    end else begin
      for (int l = 0; l < int'(W); l++) begin
        if (word_idx == WORD_W'(l / LINES_PER_WORD)) begin
          rdata_o[MODE_W*(l % LINES_PER_WORD) +: MODE_W] = mode_q[MODE_W*l +: MODE_W];
        end
      end
    end
  end

  assign mode_o = mode_q;
  assign en_o   = en_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/gpio_eint_bank.sv
module gpio_eint_bank
  import gpio_eint_pkg::*;
#(
  parameter int unsigned NUM_LINES = 32,
  parameter int unsigned ADDR_W    = 5
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] pins_i,
  input  logic                 bus_we_i,
  input  logic [ADDR_W-1:0]    bus_addr_i,
  input  logic [31:0]          bus_wdata_i,
  output logic [31:0]          bus_rdata_o,
  output logic                 irq_o
);

  logic [1:0]                  rst_sync_q;
  logic                        sys_rst_n;
  logic [NUM_LINES-1:0]        level_w;
  logic [NUM_LINES-1:0]        hit_w;
  logic [MODE_W*NUM_LINES-1:0] mode_w;
  logic [NUM_LINES-1:0]        en_w;
  logic [NUM_LINES-1:0]        pend_w;
  logic [NUM_LINES-1:0]        clr_w;
  logic                        irq_q, irq_n;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign sys_rst_n = rst_sync_q[1];

  gpio_eint_sync #(.W(NUM_LINES)) sync_i (
    .clk_i   (clk_i),
    .rst_ni  (sys_rst_n),
    .async_i (pins_i),
    .sync_o  (level_w)
  );

  gpio_eint_trigger #(.W(NUM_LINES)) trig_i (
    .clk_i   (clk_i),
    .rst_ni  (sys_rst_n),
    .level_i (level_w),
    .mode_i  (mode_w),
    .hit_o   (hit_w)
  );

  gpio_eint_regs #(.W(NUM_LINES), .ADDR_W(ADDR_W)) regs_i (
    .clk_i   (clk_i),
    .rst_ni  (sys_rst_n),
    .we_i    (bus_we_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .hit_i   (hit_w),
    .rdata_o (bus_rdata_o),
    .mode_o  (mode_w),
    .en_o    (en_w),
    .pend_o  (pend_w),
    .clr_o   (clr_w)
  );

  assign irq_n = |(pend_w & en_w);

  always_ff @(posedge clk_i or negedge sys_rst_n) begin
    if (!sys_rst_n) begin
      irq_q <= 1'b0;
    end else begin
      irq_q <= irq_n;
    end
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/gpio_eint_bank_chk.sv
module gpio_eint_bank_chk #(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_n,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      hit,
  input logic [W-1:0]      en,
  input logic [W-1:0]      pend,
  input logic [W-1:0]      clr,
  input logic [4*W-1:0]    mode,
  input logic              irq
);

  logic en_write;
  assign en_write = bus_we && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(4));

  // R7: a pending bit can only rise on a line that was enabled
  a_r7_set_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((pend & ~$past(pend) & ~$past(en)) == '0));

  // R5: bits not written with 1 are never cleared
  a_r5_zero_write_keeps: assert property (@(posedge clk_i) disable iff (!rst_n)
    (($past(pend) & ~$past(clr) & ~pend) == '0));

  // R6: an enabled trigger always leaves its pending bit set, even against a clear
  a_r6_set_wins: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((hit & en) != '0) |=> ((pend & $past(hit & en)) == $past(hit & en)));

  // R4: an enable write leaves the mode fields alone
  a_r4_enable_keeps_mode: assert property (@(posedge clk_i) disable iff (!rst_n)
    en_write |=> $stable(mode));

  // R8: the interrupt only rises from an enabled pending bit
  a_r8_irq_has_source: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(irq) |-> $past((pend & en) != '0));

endmodule

bind gpio_eint_bank gpio_eint_bank_chk #(.W(NUM_LINES), .ADDR_W(ADDR_W)) chk_i (
  .clk_i    (clk_i),
  .rst_n    (sys_rst_n),
  .bus_we   (bus_we_i),
  .bus_addr (bus_addr_i),
  .hit      (hit_w),
  .en       (en_w),
  .pend     (pend_w),
  .clr      (clr_w),
  .mode     (mode_w),
  .irq      (irq_o)
);

// File: tb/gpio_eint_bank_tb.sv
module gpio_eint_bank_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NL = 32;
  localparam logic [4:0] A_EN   = 5'h10;
  localparam logic [4:0] A_STAT = 5'h14;

  // {mode[3:0], start level, end level, expected pending}
  localparam int NVEC = 13;
  localparam logic [6:0] VEC [NVEC] = '{
    {4'd0,  1'b0, 1'b1, 1'b1},
    {4'd0,  1'b1, 1'b0, 1'b0},
    {4'd1,  1'b1, 1'b0, 1'b1},
    {4'd1,  1'b0, 1'b1, 1'b0},
    {4'd2,  1'b0, 1'b1, 1'b1},
    {4'd2,  1'b0, 1'b0, 1'b0},
    {4'd3,  1'b1, 1'b0, 1'b1},
    {4'd3,  1'b1, 1'b1, 1'b0},
    {4'd4,  1'b0, 1'b1, 1'b1},
    {4'd4,  1'b1, 1'b0, 1'b1},
    {4'd4,  1'b1, 1'b1, 1'b0},
    {4'd5,  1'b0, 1'b1, 1'b0},
    {4'd15, 1'b1, 1'b0, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NL-1:0] pins;
  logic          we;
  logic [4:0]    addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_eint_bank dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pins_i      (pins),
    .bus_we_i    (we),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; pins = '0; we = 1'b0; addr = '0; wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1: reset state
    rd(5'h00, v);  chk("R1 cfg0", v, 32'h0);
    rd(5'h0C, v);  chk("R1 cfg3", v, 32'h0);
    rd(A_EN, v);   chk("R1 enable", v, 32'h0);
    rd(A_STAT, v); chk("R1 pending", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R3: table of modes and input patterns
    for (int i = 0; i < NVEC; i++) begin
      int          line;
      logic [31:0] cfg;
      logic [3:0]  md;
      logic        st, en_lv, ex;
      {md, st, en_lv, ex} = VEC[i];
      line = (i * 5 + 1) % NL;
      cfg = 32'h7777_7777;
      cfg[4*(line%8) +: 4] = md;
      wr(5'(4 * (line / 8)), cfg);
      wr(A_EN, 32'h1 << line);
      pins = '0;
      pins[line] = st;
      idle(5);
      wr(A_STAT, 32'hFFFF_FFFF);
      idle(5);
      pins[line] = en_lv;
      idle(6);
      rd(A_STAT, v);
      chk($sformatf("R3 vec%0d pending", i), v, ex ? (32'h1 << line) : 32'h0);
      chk($sformatf("R8 vec%0d irq", i), {31'b0, irq}, {31'b0, ex});
      wr(A_EN, 32'h0);
      pins = '0;
      idle(4);
      wr(A_STAT, 32'hFFFF_FFFF);
    end

    // R2: field packing in word 1 (line 9 rising, line 8 code 7 = none)
    wr(5'h04, 32'h7777_7707);
    rd(5'h04, v); chk("R2 readback", v, 32'h7777_7707);
    wr(A_EN, 32'h0000_0300);
    idle(5);
    wr(A_STAT, 32'hFFFF_FFFF);
    pins[9:8] = 2'b11;
    idle(6);
    rd(A_STAT, v); chk("R2 only line 9 fires", v, 32'h0000_0200);

    // R8: exact latency on line 9
    pins[9:8] = 2'b00;
    idle(6);
    wr(A_STAT, 32'hFFFF_FFFF);
    idle(2);
    pins[9] = 1'b1;
    idle(2);
    rd(A_STAT, v); chk("R8 pending not yet", v, 32'h0);
    idle(1);
    rd(A_STAT, v); chk("R8 pending at third edge", v, 32'h0000_0200);
    chk("R8 irq not yet", {31'b0, irq}, 32'h0);
    idle(1);
    chk("R8 irq one edge later", {31'b0, irq}, 32'h1);

    // R5: write-one-to-clear
    wr(5'h04, 32'h7777_7700);
    pins[9:8] = 2'b00;
    idle(5);
    wr(A_STAT, 32'hFFFF_FFFF);
    pins[9:8] = 2'b11;
    idle(6);
    rd(A_STAT, v); chk("R5 both pending", v, 32'h0000_0300);
    wr(A_STAT, 32'h0000_0100);
    rd(A_STAT, v); chk("R5 clear one bit", v, 32'h0000_0200);
    wr(A_STAT, 32'h0);
    rd(A_STAT, v); chk("R5 zero write keeps", v, 32'h0000_0200);
    wr(A_STAT, v);
    rd(A_STAT, v); chk("R5 write back clears", v, 32'h0);

    // R4: enable write keeps modes
    wr(A_EN, 32'hA5A5_0000);
    rd(A_EN, v);  chk("R4 enable readback", v, 32'hA5A5_0000);
    rd(5'h04, v); chk("R4 mode unchanged", v, 32'h7777_7700);

    // R7: disabled line ignores events; disabling keeps pending
    wr(A_EN, 32'h0000_0100);
    pins[9] = 1'b0;
    idle(5);
    pins[9] = 1'b1;
    idle(6);
    rd(A_STAT, v); chk("R7 disabled line ignored", v, 32'h0);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    wr(A_EN, 32'h0000_0200);
    pins[9] = 1'b0;
    idle(5);
    pins[9] = 1'b1;
    idle(6);
    wr(A_EN, 32'h0);
    idle(2);
    rd(A_STAT, v); chk("R7 pending kept after disable", v, 32'h0000_0200);
    chk("R7 irq masked", {31'b0, irq}, 32'h0);
    wr(A_STAT, 32'hFFFF_FFFF);
    pins = '0;

    // R6: level re-sets and wins against a clear
    wr(5'h00, 32'h7777_2777);
    wr(A_EN, 32'h0000_0008);
    pins[3] = 1'b1;
    idle(6);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, v); chk("R6 set wins over clear", v, 32'h0000_0008);
    pins[3] = 1'b0;
    idle(6);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, v); chk("R6 clears once level gone", v, 32'h0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule